// File: doc/BRIEF.md
# Touch-Tone Dialing Sequencer

This block walks through a short list of 4-bit dial codes held in an external memory. For each code it drives the row and column selections that a separate dual-tone synthesizer needs, and it decides when that synthesizer may sound. Every slot opens with a fixed quiet interval. A tone burst follows, and its length is counted in sample strobes. Keypad codes produce a burst. Silence codes keep the output quiet for the whole slot. The end code stops the walk and raises a completion flag.

Each keypad key sits at a row index and a column index of a 4x3 grid. The row index selects one of 697, 770, 852 or 941 Hz. The column index selects one of 1209, 1336 or 1477 Hz. A start pulse launches the list from address 0. Both intervals are parameters counted in sample periods. Their defaults of 400 each give 50 ms at an 8 kHz sample rate, so a digit slot lasts 100 ms.

Top module: `dtmf_seq_ctrl`

## Requirements
- R1: A keypad code drives row index 0..3 (697, 770, 852, 941 Hz) and column index 0..2 (1209, 1336, 1477 Hz). The mapping is: codes 1,2,3 go to row 0; codes 4,5,6 go to row 1; codes 7,8,9 go to row 2; codes 10 (star), 0 and 11 (pound) go to row 3. Within each group the column follows the listed order.
- R2: Before any tone is enabled, a slot holds `tone_en` low for exactly GAP_LEN sample strobes counted after the code is fetched.
- R3: A keypad burst keeps `tone_en` high for exactly BURST_LEN sample strobes, and the row and column selections stay constant throughout it.
- R4: Codes 12, 13 and 14 are silence. They keep `tone_en` low for GAP_LEN+BURST_LEN strobes, after which the next address is read.
- R5: Code 15 ends the run. `done` rises in the cycle after the code is fetched, `tone_en` stays low, and `rd_addr` no longer moves.
- R6: A start pulse received while a run is active has no effect on the address, the timing or the selections.
- R7: A start pulse received while idle clears `done` in the next cycle and restarts the walk at address 0.
- R8: If the last address of the list completes without an end code, the run stops as though code 15 had followed.
- R9: After reset, `tone_en`, `done`, `rd_addr`, `row_sel` and `col_sel` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | One-cycle pulse per output sample |
| start | input | 1 | Launches the list from address 0 when idle |
| rd_addr | output | ADDR_W | Address of the code being read |
| rd_data | input | 4 | Code at `rd_addr`, valid combinationally |
| row_sel | output | 2 | Row tone index |
| col_sel | output | 2 | Column tone index |
| tone_en | output | 1 | Synthesizer enable |
| done | output | 1 | Run finished |

## Verification
The bench builds the block with GAP_LEN=5, BURST_LEN=7 and ADDR_W=4. At these values a full 16-entry list that lacks an end code runs in under a thousand cycles, which makes the exhaustion stop reachable. Every strobe of each gap and each burst is counted exactly, so an off-by-one error in either interval shows up. Four lists cover all twelve keys, silence runs both between and after keys, an immediate end code, and a start pulse issued while a slot is in progress.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef logic [3:0] dcode_t;

    localparam dcode_t CODE_STAR = 4'd10;
    localparam dcode_t CODE_HASH = 4'd11;
    localparam dcode_t CODE_QUIET = 4'd12;
    localparam dcode_t CODE_STOP = 4'd15;

    typedef struct packed {
        logic       stop;
        logic       tone;
        logic [1:0] row;
        logic [1:0] col;
    } slot_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_GAP   = 2'd2,
        ST_BURST = 2'd3
    } seq_st_t;

    function automatic slot_t classify(input dcode_t c);
        slot_t s;
        logic [3:0] k;
        s = '0;
        k = c - 4'd1;
        if (c == CODE_STOP) begin
            s.stop = 1'b1;
        end else if (c >= 4'd1 && c <= 4'd9) begin
            s.tone = 1'b1;
            s.row  = 2'(k / 4'd3);
            s.col  = 2'(k % 4'd3);
        end else if (c == 4'd0) begin
            s.tone = 1'b1;
            s.row  = 2'd3;
            s.col  = 2'd1;
        end else if (c == CODE_STAR) begin
            s.tone = 1'b1;
            s.row  = 2'd3;
            s.col  = 2'd0;
        end else if (c == CODE_HASH) begin
            s.tone = 1'b1;
            s.row  = 2'd3;
            s.col  = 2'd2;
        end
        return s;
    endfunction

endpackage

// File: rtl/dseq_decode.sv
module dseq_decode
    import dseq_pkg::*;
(
    input  dcode_t code,
    output slot_t  slot
);
    always_comb slot = classify(code);

    always_comb begin
        if (slot.tone) begin
            a_r1_col_range: assert (slot.col != 2'd3);
        end
    end
endmodule

// File: rtl/dseq_timer.sv
module dseq_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             stb,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (stb && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = stb && (cnt == CNT_W'(1));

    a_r2_load_value: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(load_val));
endmodule

// File: rtl/dseq_ptr.sv
module dseq_ptr #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            addr <= '0;
        end else if (step) begin
            addr <= addr + 1'b1;
        end
    end

    assign at_last = (addr == LAST);

    a_r8_step_one: assert property (@(posedge clk) disable iff (rst)
        (step && !clear) |=> addr == $past(addr) + 1'b1);
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clear |=> addr == '0);
endmodule

// File: rtl/dtmf_seq_ctrl.sv
module dtmf_seq_ctrl
    import dseq_pkg::*;
#(
    parameter int GAP_LEN   = 400,
    parameter int BURST_LEN = 400,
    parameter int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_stb,
    input  logic              start,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [3:0]        rd_data,
    output logic [1:0]        row_sel,
    output logic [1:0]        col_sel,
    output logic              tone_en,
    output logic              done
);
    localparam int LONGEST = (GAP_LEN > BURST_LEN) ? GAP_LEN : BURST_LEN;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] GAP_V   = CNT_W'(GAP_LEN);
    localparam logic [CNT_W-1:0] BURST_V = CNT_W'(BURST_LEN);

    initial begin
        a_r2_len_legal: assert (GAP_LEN >= 1 && BURST_LEN >= 1);
    end

    seq_st_t          state;
    slot_t            cur;
    slot_t            fetched;
    logic             done_q;
    logic             expire;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             p_clear;
    logic             p_step;
    logic             p_last;

    dseq_decode u_dec (
        .code (rd_data),
        .slot (fetched)
    );

    dseq_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .stb      (sample_stb),
        .expire   (expire)
    );

    dseq_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .clear   (p_clear),
        .step    (p_step),
        .addr    (rd_addr),
        .at_last (p_last)
    );

    always_comb begin
        t_load  = 1'b0;
        t_val   = GAP_V;
        p_clear = 1'b0;
        p_step  = 1'b0;
        case (state)
            ST_IDLE:  p_clear = start;
            ST_FETCH: t_load  = !fetched.stop;
            ST_GAP: begin
                t_load = expire;
                t_val  = BURST_V;
            end
            ST_BURST: p_step = expire && !p_last;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cur    <= '0;
            done_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        done_q <= 1'b0;
                        state  <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (fetched.stop) begin
                        done_q <= 1'b1;
                        cur    <= '0;
                        state  <= ST_IDLE;
                    end else begin
                        cur   <= fetched;
                        state <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (expire) state <= ST_BURST;
                end
                ST_BURST: begin
                    if (expire) begin
                        if (p_last) begin
                            done_q <= 1'b1;
                            cur    <= '0;
                            state  <= ST_IDLE;
                        end else begin
                            state <= ST_FETCH;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tone_en = (state == ST_BURST) && cur.tone;
    assign row_sel = cur.row;
    assign col_sel = cur.col;
    assign done    = done_q;

    a_r3_sel_hold: assert property (@(posedge clk) disable iff (rst)
        (tone_en && $past(tone_en)) |-> ($stable(row_sel) && $stable(col_sel)));
    a_r5_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !tone_en);
    a_r5_done_frozen: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> $stable(rd_addr));
    a_r6_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP && start && !expire) |=> (state == ST_GAP && $stable(rd_addr)));
    a_r7_done_clear: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> !done);
endmodule

// File: tb/tb_dtmf_seq_ctrl.sv
module tb_dtmf_seq_ctrl;
    localparam int G  = 5;
    localparam int B  = 7;
    localparam int AW = 4;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          stb;
    logic          start;
    logic [AW-1:0] rd_addr;
    logic [3:0]    rd_data;
    logic [1:0]    row_sel, col_sel;
    logic          tone_en, done;
    logic [3:0]    mem [N];

    always #5 clk = ~clk;
    assign rd_data = mem[rd_addr];

    dtmf_seq_ctrl #(.GAP_LEN(G), .BURST_LEN(B), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .sample_stb(stb), .start(start),
        .rd_addr(rd_addr), .rd_data(rd_data), .row_sel(row_sel),
        .col_sel(col_sel), .tone_en(tone_en), .done(done)
    );

    typedef struct {
        logic [1:0] r;
        logic [1:0] c;
        int         low;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad   = 0;
    int low_cnt   = 0;
    int burst_cnt = 0;
    int trail     = 0;
    logic tone_prev = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // strobe generator: one high cycle in four
    initial begin
        int ph;
        ph  = 0;
        stb = 1'b0;
        forever begin
            @(negedge clk);
            if (rst) begin
                ph  = 0;
                stb = 1'b0;
            end else begin
                stb = (ph == 3);
                ph  = (ph == 3) ? 0 : ph + 1;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst) begin
                if (stb && tone_prev) burst_cnt++;
                if (stb && !tone_prev) low_cnt++;
                if (tone_en && !tone_prev) begin
                    if (q.size() == 0) begin
                        check(1'b0, "R1 unexpected burst", 1, 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check(row_sel == e.r, "R1 row", int'(row_sel), int'(e.r));
                        check(col_sel == e.c, "R1 col", int'(col_sel), int'(e.c));
                        check(low_cnt == e.low, "R2/R4 quiet strobes", low_cnt, e.low);
                    end
                    low_cnt   = 0;
                    burst_cnt = 0;
                end
                if (!tone_en && tone_prev) begin
                    check(burst_cnt == B, "R3 burst strobes", burst_cnt, B);
                    low_cnt = 0;
                end
            end
            tone_prev = tone_en;
        end
    end

    function automatic void key_rc(input logic [3:0] c, output logic [1:0] r, output logic [1:0] k);
        if (c >= 4'd1 && c <= 4'd9) begin
            r = 2'((int'(c) - 1) / 3);
            k = 2'((int'(c) - 1) % 3);
        end else if (c == 4'd0) begin
            r = 2'd3; k = 2'd1;
        end else if (c == 4'd10) begin
            r = 2'd3; k = 2'd0;
        end else begin
            r = 2'd3; k = 2'd2;
        end
    endfunction

    task automatic build_expect();
        int pend;
        bit ended;
        pend  = 0;
        ended = 0;
        q.delete();
        for (int a = 0; a < N; a++) begin
            if (!ended) begin
                if (mem[a] == 4'd15) begin
                    ended = 1;
                end else if (mem[a] >= 4'd12) begin
                    pend += G + B;
                end else begin
                    exp_t e;
                    key_rc(mem[a], e.r, e.c);
                    e.low = pend + G;
                    q.push_back(e);
                    pend = 0;
                end
            end
        end
        trail = pend;
    endtask

    task automatic start_aligned();
        do begin
            @(posedge clk);
            #1;
        end while (!stb);
        @(negedge clk);
        start     = 1'b1;
        low_cnt   = 0;
        burst_cnt = 0;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R7 done cleared", int'(done), 0);
        check(rd_addr == '0, "R7 restart address", int'(rd_addr), 0);
    endtask

    task automatic run_list(input bit poke);
        int w;
        logic [AW-1:0] a0;
        build_expect();
        start_aligned();
        if (poke) begin
            repeat (60) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            check(rd_addr != '0, "R6 start ignored while running", int'(rd_addr), 1);
        end
        w = 0;
        while (!done && w < 5000) begin
            @(negedge clk);
            w++;
        end
        check(done == 1'b1, "R5/R8 done reached", int'(done), 1);
        check(q.size() == 0, "R1 all bursts seen", q.size(), 0);
        check(low_cnt == trail, "R4 trailing quiet strobes", low_cnt, trail);
        a0 = rd_addr;
        repeat (12) @(negedge clk);
        check(tone_en == 1'b0, "R5 quiet after done", int'(tone_en), 0);
        check(done == 1'b1, "R5 done held", int'(done), 1);
        check(rd_addr == a0, "R5 address frozen", int'(rd_addr), int'(a0));
    endtask

    initial begin
        #2_000_000;
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst   = 1'b1;
        start = 1'b0;
        for (int i = 0; i < N; i++) mem[i] = 4'd15;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tone_en == 1'b0, "R9 reset tone", int'(tone_en), 0);
        check(done == 1'b0, "R9 reset done", int'(done), 0);
        check(rd_addr == '0, "R9 reset address", int'(rd_addr), 0);
        check(row_sel == 2'd0 && col_sel == 2'd0, "R9 reset selections",
              int'({row_sel, col_sel}), 0);

        // all twelve keys then end
        for (int i = 0; i < 12; i++) mem[i] = (i == 9) ? 4'd10 : (i == 10) ? 4'd0 :
                                              (i == 11) ? 4'd11 : 4'(i + 1);
        mem[12] = 4'd15;
        run_list(1'b0);

        // silences between and after keys, start poked mid-run
        mem[0] = 4'd12; mem[1] = 4'd5;  mem[2] = 4'd13; mem[3] = 4'd14;
        mem[4] = 4'd0;  mem[5] = 4'd12; mem[6] = 4'd15;
        run_list(1'b1);

        // immediate end
        mem[0] = 4'd15;
        run_list(1'b0);
        check(rd_addr == '0, "R5 immediate end address", int'(rd_addr), 0);

        // full list without end code
        for (int i = 0; i < N; i++) mem[i] = (i % 12 == 9) ? 4'd10 : (i % 12 == 10) ? 4'd0 :
                                              (i % 12 == 11) ? 4'd11 : 4'((i % 12) + 1);
        mem[3] = 4'd12;
        run_list(1'b0);
        check(rd_addr == '1, "R8 stop at last address", int'(rd_addr), N - 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule